// File: doc/BRIEF.md
# Receive Bit-Error Counter and Alarm Monitor

This block holds the error-count and status logic of a receive bit-error-rate tester. A pattern checker upstream delivers one strobe per received bit (`bit_vld`). It also supplies the received data bit, a flag that the bit was wrong, and the level of its synchronisation state. From these inputs the block keeps a saturating error counter and watches for a long run of one bits. It latches four status conditions and drives a maskable, active-low interrupt.

The bit stream cannot be held back, so the block has no ready signal and accepts a bit on every cycle that `bit_vld` is high. Software uses a small synchronous register port with an address, a write enable, a read strobe and 16-bit data. Read data is combinational from `host_addr` and is sampled at the clock edge where `host_rd` is high. The side effects of a read take place at that same edge.

Top module: `bert_errmon`

## Requirements
- R1: While counting is enabled, each cycle with `bit_vld` and `bit_err` both high raises the error count by exactly one. No other cycle changes the count, except a clear.
- R2: The count stops at 2^CNT_W-1 and never wraps. An errored bit that brings the count to that value, or that arrives while the count is already there, sets the overflow latch.
- R3: Counting is enabled from the first cycle after reset in which `sync_ok` is high. It stays enabled after `sync_ok` falls again.
- R4: The count returns to zero one cycle after a write to address 0 that takes control bit 0 from 0 to 1. This clear wins over an errored bit in the same cycle. Writing 1 while the bit is already 1 does not clear.
- R5: The register map is as follows.
  - Address 0 holds the control bits: bit 0 clear, bit 1 sync-change enable, bit 2 error enable, bit 3 overflow enable.
  - Address 1 holds the status: bit 0 is the live loss-of-sync level (NOT `sync_ok`), bit 1 the sync-change latch, bit 2 the error latch, bit 3 the overflow latch, bit 4 the all-ones alarm, and bits 15:8 the count bits 7:0.
  - Address 2 holds the snapshot of count bits 23:8. Address 3 reads 0.
  - When `host_rd` is low, reading has no side effect.
- R6: The all-ones alarm sets when the 31st consecutive one bit is received. A status read cannot clear it until a zero bit has been received.
- R7: Every change of `sync_ok`, rising or falling, sets the sync-change latch.
- R8: An errored bit received while counting is enabled sets the error latch.
- R9: `blk_status` is the OR of each of the three latches (sync change, error, overflow) ANDed with its enable. `irq_n` is low exactly when `blk_status` is high and `irq_mask` is low.
- R10: A read of address 1 with `host_rd` high clears all four latches. A latch whose event occurs in that same cycle stays set.
- R11: The same read copies count bits 23:8 into the address 2 snapshot. Later counting or clearing does not change that snapshot until the next such read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One received bit this cycle |
| bit_data | input | 1 | Received data bit |
| bit_err | input | 1 | Received bit is in error |
| sync_ok | input | 1 | Pattern checker is in sync (level) |
| host_addr | input | 2 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (read side effects) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational from address |
| irq_mask | input | 1 | High blocks the interrupt |
| blk_status | output | 1 | OR of the enabled latches |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The checker watches the following properties on every cycle:
- the count only ever holds or steps by one;
- a count at its ceiling stays there and has set the overflow latch;
- a clear edge gives zero;
- a sync change lands in its latch;
- set latches survive until a clearing read;
- a masked interrupt stays high.

Only the bench's scenarios can show the following:
- that counting begins on the first sync;
- that counting persists once sync is lost;
- that a held clear bit is inert;
- that an event beats a clearing read in the same cycle;
- that the all-ones alarm needs a zero before it can be cleared;
- that the snapshot is coherent across the two count registers.

// File: rtl/bert_errmon_pkg.sv
package bert_errmon_pkg;
  localparam int HOST_DW = 16;
  localparam int SNAP_LO = 8;
  localparam int CNT_MAXW = 24;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CNTH = 2'd2;

  // control bit positions
  localparam int C_CLR     = 0;
  localparam int C_IE_SYNC = 1;
  localparam int C_IE_ERR  = 2;
  localparam int C_IE_OVF  = 3;

  // latch vector indices
  localparam int NLAT   = 4;
  localparam int L_SYNC = 0;
  localparam int L_ERR  = 1;
  localparam int L_OVF  = 2;
  localparam int L_ONES = 3;
endpackage

// File: rtl/bert_err_counter.sv
module bert_err_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             sat_evt
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] NEAR = MAXV - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != MAXV)  cnt <= cnt + 1'b1;
  end

  assign sat_evt = inc && !clr && (cnt == NEAR || cnt == MAXV);
endmodule

// File: rtl/bert_ones_detect.sv
module bert_ones_detect #(
  parameter int RUN = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic data,
  output logic full_nxt
);
  localparam int RW = $clog2(RUN + 1);
  localparam logic [RW-1:0] RUNV = RW'(RUN);

  logic [RW-1:0] run, run_nxt;

  always_comb begin
    run_nxt = run;
    if (vld) begin
      if (!data)             run_nxt = '0;
      else if (run != RUNV)  run_nxt = run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= run_nxt;
  end

  assign full_nxt = (run_nxt == RUNV);
endmodule

// File: rtl/bert_evt_latches.sv
module bert_evt_latches #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] lat
);
  for (genvar i = 0; i < N; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n) lat[i] <= 1'b0;
      else        lat[i] <= set[i] | (lat[i] & ~clr);
    end
  end
endmodule

// File: rtl/bert_errmon.sv
module bert_errmon
  import bert_errmon_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int ONES_RUN = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_vld,
  input  logic        bit_data,
  input  logic        bit_err,
  input  logic        sync_ok,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        irq_mask,
  output logic        blk_status,
  output logic        irq_n
);
  localparam int HI_W = CNT_MAXW - SNAP_LO;

  logic             ctrl_clr, ie_sync, ie_err, ie_ovf;
  logic             armed, sync_q;
  logic [HI_W-1:0]  snap_hi;
  logic             wr_ctrl, clr_pulse, rd_clr;
  logic             count_en, err_hit, sat_evt, ones_full, sync_chg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_MAXW-1:0] cnt24;
  logic [NLAT-1:0]  lat_set, lat;
  logic [HOST_DW-1:0] stat_word, ctrl_word;

  assign wr_ctrl   = host_wr && (host_addr == ADDR_CTRL);
  assign clr_pulse = wr_ctrl && host_wdata[C_CLR] && !ctrl_clr;
  assign rd_clr    = host_rd && (host_addr == ADDR_STAT);
  assign count_en  = armed | sync_ok;
  assign err_hit   = bit_vld & bit_err & count_en;
  assign sync_chg  = sync_ok ^ sync_q;
  assign cnt24     = CNT_MAXW'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_clr <= 1'b0;
      ie_sync  <= 1'b0;
      ie_err   <= 1'b0;
      ie_ovf   <= 1'b0;
      armed    <= 1'b0;
      sync_q   <= 1'b0;
      snap_hi  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_clr <= host_wdata[C_CLR];
        ie_sync  <= host_wdata[C_IE_SYNC];
        ie_err   <= host_wdata[C_IE_ERR];
        ie_ovf   <= host_wdata[C_IE_OVF];
      end
      armed  <= armed | sync_ok;
      sync_q <= sync_ok;
      if (rd_clr) snap_hi <= cnt24[CNT_MAXW-1:SNAP_LO];
    end
  end

  bert_err_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .inc(err_hit),
    .cnt(cnt), .sat_evt(sat_evt)
  );

  bert_ones_detect #(.RUN(ONES_RUN)) ones_i (
    .clk(clk), .rst_n(rst_n), .vld(bit_vld), .data(bit_data),
    .full_nxt(ones_full)
  );

  always_comb begin
    lat_set         = '0;
    lat_set[L_SYNC] = sync_chg;
    lat_set[L_ERR]  = err_hit;
    lat_set[L_OVF]  = sat_evt;
    lat_set[L_ONES] = ones_full;
  end

  bert_evt_latches #(.N(NLAT)) lat_i (
    .clk(clk), .rst_n(rst_n), .set(lat_set), .clr(rd_clr), .lat(lat)
  );

  always_comb begin
    stat_word        = '0;
    stat_word[0]     = ~sync_ok;
    stat_word[1]     = lat[L_SYNC];
    stat_word[2]     = lat[L_ERR];
    stat_word[3]     = lat[L_OVF];
    stat_word[4]     = lat[L_ONES];
    stat_word[15:8]  = cnt24[SNAP_LO-1:0];
    ctrl_word            = '0;
    ctrl_word[C_CLR]     = ctrl_clr;
    ctrl_word[C_IE_SYNC] = ie_sync;
    ctrl_word[C_IE_ERR]  = ie_err;
    ctrl_word[C_IE_OVF]  = ie_ovf;
  end

  always_comb begin
    case (host_addr)
      ADDR_CTRL: host_rdata = ctrl_word;
      ADDR_STAT: host_rdata = stat_word;
      ADDR_CNTH: host_rdata = snap_hi;
      default:   host_rdata = '0;
    endcase
  end

  assign blk_status = (lat[L_SYNC] & ie_sync) | (lat[L_ERR] & ie_err) |
                      (lat[L_OVF] & ie_ovf);
  assign irq_n = ~(blk_status & ~irq_mask);
endmodule

// File: rtl/bert_errmon_chk.sv
module bert_errmon_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             clr_pulse,
  input logic             rd_clr,
  input logic [3:0]       lat,
  input logic             sync_ok,
  input logic             sync_q,
  input logic             irq_mask,
  input logic             irq_n
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr_pulse) |=> cnt == MAXV);

  p_sat_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != MAXV) ##1 (cnt == MAXV) |-> lat[2]);

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> cnt == '0);

  p_sync_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok != sync_q) |=> lat[0]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lat[0] && !rd_clr) |=> lat[0]);

  p_ones_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat[3] && !rd_clr) |=> lat[3]);

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> irq_n);
endmodule

bind bert_errmon bert_errmon_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .clr_pulse(clr_pulse),
  .rd_clr(rd_clr), .lat(lat), .sync_ok(sync_ok), .sync_q(sync_q),
  .irq_mask(irq_mask), .irq_n(irq_n)
);

// File: tb/bert_errmon_tb_top.sv
`timescale 1ns/1ps
module bert_errmon_tb_top;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 0, bit_data = 0, bit_err = 0, sync_ok = 0;
  logic [1:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0, irq_mask = 0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic blk_status, irq_n;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bert_errmon #(.CNT_W(CW), .ONES_RUN(31)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_data(bit_data),
    .bit_err(bit_err), .sync_ok(sync_ok), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_mask(irq_mask),
    .blk_status(blk_status), .irq_n(irq_n)
  );

  // {vld, sync, err, expected count}
  localparam logic [10:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b1, 8'd0}, {1'b1, 1'b1, 1'b0, 8'd0},
    {1'b1, 1'b1, 1'b1, 8'd1}, {1'b1, 1'b1, 1'b1, 8'd2},
    {1'b1, 1'b1, 1'b0, 8'd2}, {1'b1, 1'b0, 1'b1, 8'd3},
    {1'b1, 1'b0, 1'b1, 8'd4}, {1'b1, 1'b1, 1'b0, 8'd4},
    {1'b1, 1'b1, 1'b1, 8'd5}, {1'b0, 1'b1, 1'b1, 8'd5}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic e, input logic d);
    @(negedge clk);
    bit_vld = v; sync_ok = s; bit_err = e; bit_data = d;
    @(posedge clk); #1;
    bit_vld = 0; bit_err = 0; bit_data = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a; #1;
    v = host_rdata;
  endtask

  task automatic rd_clear(output logic [15:0] v);
    @(negedge clk);
    host_addr = 2'd1; host_rd = 1; #1;
    v = host_rdata;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    host_addr = 2'd0; host_wr = 1; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset state
    peek(2'd1, v); chk("R5 reset status", v, 16'h0001);
    peek(2'd0, v); chk("R5 reset ctrl", v, 16'h0000);
    chk("R9 reset irq_n", {15'd0, irq_n}, 16'd1);

    // vector walk: R1 counting, R3 start on sync and persistence
    for (int i = 0; i < 10; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8], 1'b0);
      peek(2'd1, v);
      chk($sformatf("R1/R3 vec %0d", i), {8'd0, v[15:8]}, {8'd0, VEC[i][7:0]});
    end

    // R7/R8 latches, R10 clear by read
    rd_clear(v); chk("R7/R8 status latched", v, 16'h0506);
    peek(2'd1, v); chk("R10 latches cleared", v, 16'h0500);

    // R4 clear edge beats same-cycle error
    @(negedge clk);
    host_addr = 2'd0; host_wr = 1; host_wdata = 16'h0001;
    bit_vld = 1; bit_err = 1;
    @(posedge clk); #1;
    host_wr = 0; bit_vld = 0; bit_err = 0;
    peek(2'd1, v); chk("R4 clear wins", {8'd0, v[15:8]}, 16'd0);
    step(1, 1, 1, 0);
    wr(16'h0001);
    peek(2'd1, v); chk("R4 held bit no clear", {8'd0, v[15:8]}, 16'd1);
    wr(16'h0000);
    wr(16'h0001);
    peek(2'd1, v); chk("R4 new edge clears", {8'd0, v[15:8]}, 16'd0);
    rd_clear(v);

    // R9 interrupt path
    wr(16'h0004);
    chk("R9 idle irq", {15'd0, irq_n}, 16'd1);
    step(1, 1, 1, 0); #1;
    chk("R9 err irq", {15'd0, irq_n}, 16'd0);
    irq_mask = 1; #1;
    chk("R9 masked", {15'd0, irq_n}, 16'd1);
    chk("R9 blk_status", {15'd0, blk_status}, 16'd1);
    irq_mask = 0;

    // R10 event in same cycle as clearing read survives
    @(negedge clk);
    host_addr = 2'd1; host_rd = 1; bit_vld = 1; bit_err = 1;
    @(posedge clk); #1;
    host_rd = 0; bit_vld = 0; bit_err = 0;
    peek(2'd1, v); chk("R10 concurrent event kept", {15'd0, v[2]}, 16'd1);
    rd_clear(v); #1;
    chk("R10 irq released", {15'd0, irq_n}, 16'd1);

    // R7 both directions, enable gating
    wr(16'h0002);
    step(1, 1, 1, 0); #1;
    chk("R9 err disabled", {15'd0, irq_n}, 16'd1);
    step(0, 0, 0, 0); #1;
    chk("R7 sync loss irq", {15'd0, irq_n}, 16'd0);
    rd_clear(v);
    step(0, 1, 0, 0);
    peek(2'd1, v); chk("R7 sync regain latch", {15'd0, v[1]}, 16'd1);
    rd_clear(v);
    wr(16'h0000);

    // R6 all-ones alarm
    for (int i = 0; i < 30; i++) step(1, 1, 0, 1);
    peek(2'd1, v); chk("R6 30 ones", {15'd0, v[4]}, 16'd0);
    step(1, 1, 0, 1);
    peek(2'd1, v); chk("R6 31 ones", {15'd0, v[4]}, 16'd1);
    rd_clear(v);
    peek(2'd1, v); chk("R6 read before zero", {15'd0, v[4]}, 16'd1);
    step(1, 1, 0, 0);
    peek(2'd1, v); chk("R6 still latched", {15'd0, v[4]}, 16'd1);
    rd_clear(v);
    peek(2'd1, v); chk("R6 cleared", {15'd0, v[4]}, 16'd0);

    // R2 saturation, R11 snapshot
    wr(16'h0001);
    wr(16'h0008);
    rd_clear(v);
    for (int i = 0; i < 4094; i++) step(1, 1, 1, 0);
    peek(2'd1, v); chk("R2 before top", v, 16'hFE04);
    chk("R2 irq before top", {15'd0, irq_n}, 16'd1);
    step(1, 1, 1, 0);
    peek(2'd1, v); chk("R2 at top", v, 16'hFF0C);
    chk("R2 ovf irq", {15'd0, irq_n}, 16'd0);
    step(1, 1, 1, 0);
    rd_clear(v); chk("R2 no wrap", {8'd0, v[15:8]}, 16'h00FF);
    peek(2'd2, v); chk("R11 snapshot high", v, 16'h000F);
    wr(16'h0001);
    peek(2'd1, v); chk("R4 clear after top", {8'd0, v[15:8]}, 16'd0);
    peek(2'd2, v); chk("R11 snapshot held", v, 16'h000F);
    peek(2'd3, v); chk("R5 unused addr", v, 16'h0000);

    summary();
    $finish;
  end
endmodule